// File: doc/BRIEF.md
# Pareto Dominance Tournament Selector

This block picks a parent for breeding in a hardware evolutionary optimiser. Each candidate circuit carries a vector of three scores: functional quality, area score and speed score. All three are unsigned fixed-point values, and higher is better for every one. When a request is accepted, the block takes two candidate indices from an external random input and puts them on its index outputs. A score store outside the block answers with the score vectors and the precomputed rank values of those two candidates. The block then decides a binary tournament between them.

The block runs a fixed number of rounds (`ROUNDS`, default two). After the first round, the winner so far meets one newly drawn challenger in each round. The winner of the last round is returned as the parent index, together with a one-cycle grant pulse.

A mode bit chooses between two comparison rules. Plain mode uses Pareto dominance alone. Preferred mode first looks at functional quality, which is the main objective. Only when the two qualities are equal does it fall back to Pareto dominance.

Top module: `pareto_tourney_sel`

## Requirements
- R1: After reset, `busy_o` is 0, `gnt_o` is 0 and `parent_idx_o` is 0.
- R2: In plain mode, candidate X wins if it dominates Y. Dominance means X is greater than or equal to Y in every objective and strictly greater in at least one.
- R3: Every objective is maximised. The objective vector packs quality in bits [15:0], area score in [31:16] and speed score in [47:32].
- R4: In preferred mode, a candidate with strictly higher quality wins, whatever its other two scores are.
- R5: In preferred mode with equal quality, the decision falls back to the Pareto dominance rule of R2.
- R6: When neither candidate dominates the other, the candidate with the strictly lower rank input wins.
- R7: When the rank values are also equal, the candidate with the lower index wins. If the two indices are equal, that index wins.
- R8: On acceptance, `rnd_i[7:0]` becomes candidate A and `rnd_i[15:8]` becomes candidate B for round 0. Both are visible on the index outputs in the cycle after acceptance. In each later round, candidate A is the previous winner and candidate B is `rnd_i[15:8]`, sampled at the clock edge that ends the previous round.
- R9: `gnt_o` is a single-cycle pulse. It rises exactly `ROUNDS` cycles after the accepting edge. `parent_idx_o` is the winner of the last round and holds until the next grant.
- R10: A request is accepted only while `busy_o` is 0. A request made while busy changes neither the candidates, the grant timing nor the result, and it does not start a new selection.
- R11: The mode is sampled once, at acceptance. Changing `pref_mode_i` during a selection has no effect on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Selection request |
| pref_mode_i | input | 1 | 1 = quality first, 0 = plain Pareto |
| rnd_i | input | 16 | Random draws: [7:0] first A, [15:8] B |
| cand_a_idx_o | output | 8 | Index of candidate A under test |
| cand_b_idx_o | output | 8 | Index of candidate B under test |
| obj_a_i | input | 48 | Score vector of candidate A |
| obj_b_i | input | 48 | Score vector of candidate B |
| rank_a_i | input | 8 | Rank value of candidate A |
| rank_b_i | input | 8 | Rank value of candidate B |
| busy_o | output | 1 | Selection in progress |
| gnt_o | output | 1 | One-cycle result strobe |
| parent_idx_o | output | 8 | Selected parent index |

## Verification
The bench sweeps every ordered pair of 64 candidates in both modes. Its score table makes every dominance pattern occur, including equal vectors, equal ranks and equal indices. Each case is tagged with the rule that decides it. Several wrong designs show up this way. A design that treats equality as dominance, or that minimises a score, picks the wrong parent in the mixed-score cases. A design that consults quality in plain mode, or ignores it in preferred mode, fails the R4 and R2 cases. A swapped tie-break fails whenever the ranks or the indices differ in only one direction. Some selections also raise the request and flip the mode in mid-flight. A design that restarts on such a request, or that re-reads the mode late, shifts the grant or changes the parent.

// File: rtl/ptsel_pkg.sv
package ptsel_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ptsel_state_e;

    // slot of the main (preferred) objective inside a score vector
    localparam int unsigned QUAL_SLOT = 0;
endpackage

// File: rtl/ptsel_dominance.sv
module ptsel_dominance #(
    parameter int unsigned OBJ_W = 16,
    parameter int unsigned N_OBJ = 3
) (
    input  logic [N_OBJ*OBJ_W-1:0] vec_x_i,
    input  logic [N_OBJ*OBJ_W-1:0] vec_y_i,
    output logic                   x_dom_y_o
);
    logic [N_OBJ-1:0] ge_v;
    logic [N_OBJ-1:0] gt_v;

    for (genvar k = 0; k < N_OBJ; k++) begin : g_obj
        logic [OBJ_W-1:0] sx;
        logic [OBJ_W-1:0] sy;
        assign sx      = vec_x_i[k*OBJ_W +: OBJ_W];
        assign sy      = vec_y_i[k*OBJ_W +: OBJ_W];
        assign ge_v[k] = (sx >= sy);
        assign gt_v[k] = (sx > sy);
    end

    assign x_dom_y_o = (&ge_v) && (|gt_v);
endmodule

// File: rtl/ptsel_judge.sv
module ptsel_judge
    import ptsel_pkg::*;
#(
    parameter int unsigned OBJ_W  = 16,
    parameter int unsigned N_OBJ  = 3,
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned RANK_W = 8
) (
    input  logic [N_OBJ*OBJ_W-1:0] vec_a_i,
    input  logic [N_OBJ*OBJ_W-1:0] vec_b_i,
    input  logic [RANK_W-1:0]      rank_a_i,
    input  logic [RANK_W-1:0]      rank_b_i,
    input  logic [IDX_W-1:0]       idx_a_i,
    input  logic [IDX_W-1:0]       idx_b_i,
    input  logic                   pref_i,
    output logic                   pick_b_o
);
    logic             a_dom;
    logic             b_dom;
    logic [OBJ_W-1:0] qual_a;
    logic [OBJ_W-1:0] qual_b;

    ptsel_dominance #(.OBJ_W(OBJ_W), .N_OBJ(N_OBJ)) u_dom_ab (
        .vec_x_i  (vec_a_i),
        .vec_y_i  (vec_b_i),
        .x_dom_y_o(a_dom)
    );

    ptsel_dominance #(.OBJ_W(OBJ_W), .N_OBJ(N_OBJ)) u_dom_ba (
        .vec_x_i  (vec_b_i),
        .vec_y_i  (vec_a_i),
        .x_dom_y_o(b_dom)
    );

    assign qual_a = vec_a_i[QUAL_SLOT*OBJ_W +: OBJ_W];
    assign qual_b = vec_b_i[QUAL_SLOT*OBJ_W +: OBJ_W];

    always_comb begin
        if (pref_i && (qual_a != qual_b)) begin
            pick_b_o = (qual_b > qual_a);
        end else if (a_dom) begin
            pick_b_o = 1'b0;
        end else if (b_dom) begin
            pick_b_o = 1'b1;
        end else if (rank_a_i != rank_b_i) begin
            pick_b_o = (rank_b_i < rank_a_i);
        end else begin
            pick_b_o = (idx_b_i < idx_a_i);
        end
    end
endmodule

// File: rtl/pareto_tourney_sel.sv
module pareto_tourney_sel
    import ptsel_pkg::*;
#(
    parameter int unsigned OBJ_W  = 16,
    parameter int unsigned N_OBJ  = 3,
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned RANK_W = 8,
    parameter int unsigned ROUNDS = 2
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   req_i,
    input  logic                   pref_mode_i,
    input  logic [2*IDX_W-1:0]     rnd_i,
    output logic [IDX_W-1:0]       cand_a_idx_o,
    output logic [IDX_W-1:0]       cand_b_idx_o,
    input  logic [N_OBJ*OBJ_W-1:0] obj_a_i,
    input  logic [N_OBJ*OBJ_W-1:0] obj_b_i,
    input  logic [RANK_W-1:0]      rank_a_i,
    input  logic [RANK_W-1:0]      rank_b_i,
    output logic                   busy_o,
    output logic                   gnt_o,
    output logic [IDX_W-1:0]       parent_idx_o
);
    localparam int unsigned CNT_W    = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
    localparam logic [CNT_W-1:0] LAST_RND = CNT_W'(ROUNDS - 1);

    typedef struct packed {
        ptsel_state_e     state;
        logic [CNT_W-1:0] round;
        logic [IDX_W-1:0] idx_a;
        logic [IDX_W-1:0] idx_b;
        logic             pref;
        logic [IDX_W-1:0] parent;
        logic             gnt;
    } sel_regs_t;

    sel_regs_t        cur_q;
    sel_regs_t        nxt_d;
    logic             pick_b;
    logic [IDX_W-1:0] winner;
    logic             pref_q;

    ptsel_judge #(
        .OBJ_W (OBJ_W),
        .N_OBJ (N_OBJ),
        .IDX_W (IDX_W),
        .RANK_W(RANK_W)
    ) u_judge (
        .vec_a_i (obj_a_i),
        .vec_b_i (obj_b_i),
        .rank_a_i(rank_a_i),
        .rank_b_i(rank_b_i),
        .idx_a_i (cur_q.idx_a),
        .idx_b_i (cur_q.idx_b),
        .pref_i  (cur_q.pref),
        .pick_b_o(pick_b)
    );

    assign winner = pick_b ? cur_q.idx_b : cur_q.idx_a;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.gnt = 1'b0;
        case (cur_q.state)
            ST_IDLE: begin
                if (req_i) begin
                    nxt_d.state = ST_RUN;
                    nxt_d.round = '0;
                    nxt_d.pref  = pref_mode_i;
                    nxt_d.idx_a = rnd_i[IDX_W-1:0];
                    nxt_d.idx_b = rnd_i[2*IDX_W-1:IDX_W];
                end
            end
            ST_RUN: begin
                if (cur_q.round == LAST_RND) begin
                    nxt_d.state  = ST_IDLE;
                    nxt_d.parent = winner;
                    nxt_d.gnt    = 1'b1;
                end else begin
                    nxt_d.round = cur_q.round + 1'b1;
                    nxt_d.idx_a = winner;
                    nxt_d.idx_b = rnd_i[2*IDX_W-1:IDX_W];
                end
            end
            default: nxt_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q <= '{state: ST_IDLE, round: '0, idx_a: '0, idx_b: '0,
                       pref: 1'b0, parent: '0, gnt: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign pref_q       = cur_q.pref;
    assign cand_a_idx_o = cur_q.idx_a;
    assign cand_b_idx_o = cur_q.idx_b;
    assign busy_o       = (cur_q.state == ST_RUN);
    assign gnt_o        = cur_q.gnt;
    assign parent_idx_o = cur_q.parent;
endmodule

// File: rtl/ptsel_chk.sv
module ptsel_chk #(
    parameter int unsigned OBJ_W = 16,
    parameter int unsigned IDX_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             req_i,
    input logic             busy_o,
    input logic             gnt_o,
    input logic [IDX_W-1:0] parent_idx_o,
    input logic [IDX_W-1:0] cand_a_idx_o,
    input logic [IDX_W-1:0] cand_b_idx_o,
    input logic [OBJ_W-1:0] qual_a,
    input logic [OBJ_W-1:0] qual_b,
    input logic             pref_q
);
    // R9: the grant lasts one cycle
    a_r9_gnt_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gnt_o |=> !gnt_o);

    // R9: a grant is preceded by a busy cycle
    a_r9_gnt_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(gnt_o) |-> $past(busy_o));

    // R10: without a request an idle block stays idle
    a_r10_idle_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !req_i) |=> !busy_o);

    // R9: parent is one of the final pair
    a_r9_parent_from_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gnt_o |-> (parent_idx_o == $past(cand_a_idx_o) ||
                   parent_idx_o == $past(cand_b_idx_o)));

    // R8: the carried candidate A is a winner of the previous pair
    a_r8_carry_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o)) |-> (cand_a_idx_o == $past(cand_a_idx_o) ||
                                       cand_a_idx_o == $past(cand_b_idx_o)));

    // R4: in preferred mode a strictly higher quality wins the final round
    a_r4_quality_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gnt_o && $past(pref_q) && ($past(qual_a) > $past(qual_b)) &&
         $past(cand_a_idx_o) != $past(cand_b_idx_o))
        |-> parent_idx_o == $past(cand_a_idx_o));
endmodule

bind pareto_tourney_sel ptsel_chk #(.OBJ_W(OBJ_W), .IDX_W(IDX_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .busy_o      (busy_o),
    .gnt_o       (gnt_o),
    .parent_idx_o(parent_idx_o),
    .cand_a_idx_o(cand_a_idx_o),
    .cand_b_idx_o(cand_b_idx_o),
    .qual_a      (obj_a_i[OBJ_W-1:0]),
    .qual_b      (obj_b_i[OBJ_W-1:0]),
    .pref_q      (pref_q)
);

// File: tb/sim_pareto_tourney_sel.sv
module sim_pareto_tourney_sel;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        pref = 1'b0;
    logic [15:0] rnd = '0;
    logic [7:0]  cand_a, cand_b;
    logic [47:0] obj_a, obj_b;
    logic [7:0]  rank_a, rank_b;
    logic        busy, gnt;
    logic [7:0]  parent;
    int          checks = 0;
    int          fails = 0;
    int          cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pareto_tourney_sel u0 (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .pref_mode_i(pref),
        .rnd_i(rnd), .cand_a_idx_o(cand_a), .cand_b_idx_o(cand_b),
        .obj_a_i(obj_a), .obj_b_i(obj_b), .rank_a_i(rank_a), .rank_b_i(rank_b),
        .busy_o(busy), .gnt_o(gnt), .parent_idx_o(parent)
    );

    function automatic logic [15:0] score(input logic [7:0] i, input int k);
        case (k)
            0: score = 16'(i[1:0]) * 16'd1000;
            1: score = 16'(i[3:2]) * 16'd300;
            default: score = 16'(i[5:4]) * 16'd77;
        endcase
    endfunction

    function automatic logic [7:0] rankf(input logic [7:0] i);
        rankf = {6'd0, i[0] ^ i[3], i[5]};
    endfunction

    function automatic logic [47:0] vecf(input logic [7:0] i);
        vecf = {score(i, 2), score(i, 1), score(i, 0)};
    endfunction

    always_comb begin
        obj_a  = vecf(cand_a);
        obj_b  = vecf(cand_b);
        rank_a = rankf(cand_a);
        rank_b = rankf(cand_b);
    end

    // reference: returns winner, and which rule decided (4,2,6,7)
    function automatic logic [7:0] ref_win(input logic [7:0] a, input logic [7:0] b,
                                           input logic p, output int rule);
        int ge_ab = 1, gt_ab = 0, ge_ba = 1, gt_ba = 0;
        for (int k = 0; k < 3; k++) begin
            if (score(a, k) < score(b, k)) ge_ab = 0;
            if (score(a, k) > score(b, k)) gt_ab = 1;
            if (score(b, k) < score(a, k)) ge_ba = 0;
            if (score(b, k) > score(a, k)) gt_ba = 1;
        end
        if (p && score(a, 0) != score(b, 0)) begin
            rule = 4;
            return (score(a, 0) > score(b, 0)) ? a : b;
        end
        if (ge_ab == 1 && gt_ab == 1) begin rule = p ? 5 : 2; return a; end
        if (ge_ba == 1 && gt_ba == 1) begin rule = p ? 5 : 2; return b; end
        if (rankf(a) != rankf(b)) begin
            rule = 6;
            return (rankf(a) < rankf(b)) ? a : b;
        end
        rule = 7;
        return (a <= b) ? a : b;
    endfunction

    function automatic string tagof(input int rule);
        case (rule)
            4: tagof = "R4";
            5: tagof = "R5";
            2: tagof = "R2/R3";
            6: tagof = "R6";
            default: tagof = "R7";
        endcase
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                       input logic p, input logic disturb);
        int r0, r1;
        logic [7:0] w0, w1;
        w0 = ref_win(a, b, p, r0);
        w1 = ref_win(w0, c, p, r1);
        @(negedge clk);
        req = 1'b1; pref = p; rnd = {b, a};
        @(negedge clk);
        req = disturb; rnd = {c, 8'hA5};
        if (disturb) pref = ~p;   // R11 mode flip, R10 request while busy
        check(busy == 1'b1, "R8 busy", int'(busy), 1);
        check(cand_a == a && cand_b == b, "R8 round0 pair", int'({cand_a, cand_b}), int'({a, b}));
        @(negedge clk);
        req = 1'b0; rnd = {8'h5A, 8'h3C};
        check(cand_a == w0 && cand_b == c, "R8 round1 pair", int'({cand_a, cand_b}), int'({w0, c}));
        check(gnt == 1'b0, "R9 early gnt", int'(gnt), 0);
        @(negedge clk);
        check(gnt == 1'b1, "R9 gnt", int'(gnt), 1);
        check(parent == w1, disturb ? "R10/R11 result" : tagof(r1), int'(parent), int'(w1));
        check(busy == 1'b0, "R10 no restart", int'(busy), 0);
        @(negedge clk);
        check(gnt == 1'b0 && parent == w1, "R9 pulse/hold", int'({gnt, parent}), int'(w1));
    endtask

    initial begin
        #(CLK_PERIOD * 3);
        // R1 reset state
        check(busy == 1'b0 && gnt == 1'b0 && parent == 8'd0, "R1 reset",
              int'({busy, gnt, parent}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R1 idle", int'(busy), 0);
        for (int p = 0; p < 2; p++) begin
            for (int a = 0; a < 64; a++) begin
                for (int b = 0; b < 64; b++) begin
                    logic [7:0] c;
                    c = 8'((a * 7 + b * 3 + 1) & 63);
                    if (((a + b) % 9) == 0) c = 8'(a);
                    run(8'(a), 8'(b), c, p[0], ((a + 2 * b) % 5) == 0);
                end
            end
        end
        // equal indices throughout: R7
        run(8'd200, 8'd200, 8'd200, 1'b0, 1'b0);
        run(8'd17, 8'd17, 8'd17, 1'b1, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++;
                fails++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end
endmodule